// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of interrupt sources and a simple processor core. Each of eight priority levels has one request line; level 7 outranks all others and level 0 is the lowest. A rising edge on a line marks that level pending. A level holds one pending request at most, so a second edge before service merges with the first. The core pulses a strobe each time an instruction completes. Only on that strobe does the controller look for a pending level that the current mask allows. If it finds one, it reads the handler address from a vector table in low memory. It then issues a one-cycle take pulse with the level, the table address and the handler address. The take pulse also tells the core to save its return address.

While a level is in service, that level and every level below it are masked, and only a strictly higher level can preempt it. Nested levels are recorded on an in-service stack. A return pulse from the core pops the stack and restores the mask of the interrupted level. A global enable stops new takes altogether. When the nesting enable is low, no take starts while any handler is running. Masked requests stay pending and are taken at the first instruction boundary after the mask allows them.

The sequencer has four states. PV_IDLE waits for a boundary. The start transition PV_IDLE→PV_READ fires when the strobe, the global enable and an eligible pending level coincide. PV_READ drives the table read, and PV_READ→PV_WAIT is unconditional. The table word is captured on PV_WAIT→PV_TAKE. PV_TAKE emits the take pulse, pushes the level and clears its pending bit on PV_TAKE→PV_IDLE.

Top module: `pvic_top`

## Requirements
- R1: After reset, take_o and vt_rd_en_o are low, no level is pending or in service, and a boundary with no request produces no table read and no take.
- R2: Requests are edge-detected: a line held high produces exactly one request, and no second take follows after its handler returns.
- R3: A take starts only from a boundary strobe while the sequencer is idle. Among pending levels the mask allows, the highest index wins.
- R4: vt_rd_en_o is high for the single cycle after the accepted strobe, with vt_rd_addr_o = VT_BASE + 4 × level. Two cycles later take_o is high for exactly one cycle. In that cycle take_level_o is the level, take_vaddr_o is the same table address, and take_handler_o is the word returned on vt_rd_data_i one cycle after the read.
- R5: While a level is in service, pending requests at that level and below are not taken. A pending request at a strictly higher level is taken and nests.
- R6: A return pulse pops the in-service stack. The mask becomes that of the interrupted level, or no mask when the stack empties.
- R7: Two or more edges on one level before it is taken yield a single take.
- R8: A request that is masked stays pending. It is taken at the first boundary after the mask no longer covers it.
- R9: While int_en_i is low no take starts, and pending requests are kept.
- R10: While nest_en_i is low and any level is in service, no take starts.
- R11: A new edge on a level in the same cycle that level's take completes leaves the level pending.
- R12: A return pulse in the take cycle pops the old top before the new level is pushed. The stack depth is unchanged and the new level becomes the top.
- R13: A return pulse while nothing is in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NUM_LVL | Request lines, bit n is level n |
| insn_done_i | input | 1 | Instruction-boundary strobe |
| int_en_i | input | 1 | Global interrupt enable |
| nest_en_i | input | 1 | Allow preemption of a running handler |
| ret_i | input | 1 | Return-from-handler pulse |
| vt_rd_en_o | output | 1 | Vector table read strobe |
| vt_rd_addr_o | output | ADDR_W | Vector table read address |
| vt_rd_data_i | input | ADDR_W | Vector table word, one cycle after the read |
| take_o | output | 1 | Take pulse; core saves its return address |
| take_level_o | output | clog2(NUM_LVL) | Level being taken |
| take_vaddr_o | output | ADDR_W | Table address used for this take |
| take_handler_o | output | ADDR_W | Handler address to load into the instruction counter |

## Verification
Two pairs of events can land in the same cycle. A take clears a level's pending bit while a new edge on that level sets it. A take pushes the stack while the core's return pulse pops it. The bench provokes both by raising the request line, or the return pulse, exactly in the take cycle. It judges the outcome at later boundaries. The level must be taken again once its own handler returns. A low level must be taken directly after a single further return, which proves the old top was removed and the new level sits alone on the stack.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    typedef enum logic [1:0] {
        PV_IDLE = 2'd0,
        PV_READ = 2'd1,
        PV_WAIT = 2'd2,
        PV_TAKE = 2'd3
    } pvic_state_e;

endpackage

// File: rtl/pvic_req_capture.sv
module pvic_req_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= req_i;
        end
    end

    // One pending flag per level; a fresh edge wins over a clear.
    for (genvar g = 0; g < N; g++) begin : g_lvl
        logic flag_q;
        logic rise;

        assign rise = req_i[g] & ~prev_q[g];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (rise) begin
                flag_q <= 1'b1;
            end else if (clr_i[g]) begin
                flag_q <= 1'b0;
            end
        end

        assign pend_o[g] = flag_q;
    end

endmodule

// File: rtl/pvic_prio_pick.sv
module pvic_prio_pick #(
    parameter int N  = 8,
    parameter int LW = 3
) (
    input  logic [N-1:0]  pend_i,
    input  logic [N-1:0]  elig_i,
    output logic          valid_o,
    output logic [LW-1:0] lvl_o
);

    logic [N-1:0] cand;

    // Scan upward so the highest eligible index is the last one kept.
    always_comb begin
        cand    = pend_i & elig_i;
        valid_o = 1'b0;
        lvl_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i]) begin
                valid_o = 1'b1;
                lvl_o   = LW'(i);
            end
        end
    end

endmodule

// File: rtl/pvic_svc_stack.sv
module pvic_svc_stack #(
    parameter int DEPTH = 8,
    parameter int LW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [LW-1:0] push_lvl_i,
    output logic [LW-1:0] top_o,
    output logic          empty_o,
    output logic          full_o
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LW-1:0] mem_q [DEPTH];
    logic [CW-1:0] cnt_q;
    logic          do_pop;
    logic          do_push;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] top_idx;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign do_pop  = pop_i && !empty_o;
    // A pop in the same cycle frees the slot the push will use.
    assign do_push = push_i && (!full_o || do_pop);
    assign top_idx = IW'(cnt_q - CW'(1));
    assign wr_idx  = do_pop ? top_idx : IW'(cnt_q);
    assign top_o   = empty_o ? '0 : mem_q[top_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (do_push) begin
            mem_q[wr_idx] <= push_lvl_i;
        end
    end

endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int                  NUM_LVL   = 8,
    parameter int                  STK_DEPTH = 8,
    parameter int                  ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]   VT_BASE   = 16'h0040
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LVL-1:0]         irq_i,
    input  logic                       insn_done_i,
    input  logic                       int_en_i,
    input  logic                       nest_en_i,
    input  logic                       ret_i,
    output logic                       vt_rd_en_o,
    output logic [ADDR_W-1:0]          vt_rd_addr_o,
    input  logic [ADDR_W-1:0]          vt_rd_data_i,
    output logic                       take_o,
    output logic [$clog2(NUM_LVL)-1:0] take_level_o,
    output logic [ADDR_W-1:0]          take_vaddr_o,
    output logic [ADDR_W-1:0]          take_handler_o
);

    localparam int LVL_W = $clog2(NUM_LVL);

    pvic_state_e          state_q;
    pvic_state_e          state_d;
    logic [NUM_LVL-1:0]   pend;
    logic [NUM_LVL-1:0]   clr_vec;
    logic [NUM_LVL-1:0]   elig;
    logic                 win_valid;
    logic [LVL_W-1:0]     win_lvl;
    logic [LVL_W-1:0]     stk_top;
    logic                 stk_empty;
    logic                 stk_full;
    logic                 push;
    logic                 start;
    logic                 st_idle;
    logic [LVL_W-1:0]     sel_q;
    logic [ADDR_W-1:0]    handler_q;
    logic [ADDR_W-1:0]    vaddr;

    pvic_req_capture #(
        .N (NUM_LVL)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_i),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    // Mask: nothing in service -> all levels; otherwise only strictly above the top.
    always_comb begin
        for (int i = 0; i < NUM_LVL; i++) begin
            elig[i] = stk_empty ? 1'b1 : (nest_en_i && (i > int'(stk_top)));
        end
    end

    pvic_prio_pick #(
        .N  (NUM_LVL),
        .LW (LVL_W)
    ) u_pick (
        .pend_i  (pend),
        .elig_i  (elig),
        .valid_o (win_valid),
        .lvl_o   (win_lvl)
    );

    pvic_svc_stack #(
        .DEPTH (STK_DEPTH),
        .LW    (LVL_W)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .pop_i      (ret_i),
        .push_lvl_i (sel_q),
        .top_o      (stk_top),
        .empty_o    (stk_empty),
        .full_o     (stk_full)
    );

    assign start = (state_q == PV_IDLE) && insn_done_i && int_en_i && win_valid;
    assign vaddr = VT_BASE + ADDR_W'({sel_q, 2'b00});

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PV_IDLE: if (start) state_d = PV_READ;
            PV_READ: state_d = PV_WAIT;
            PV_WAIT: state_d = PV_TAKE;
            PV_TAKE: state_d = PV_IDLE;
            default: state_d = PV_IDLE;
        endcase
    end

    // Data captured along the sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= '0;
            handler_q <= '0;
        end else begin
            if (start) begin
                sel_q <= win_lvl;
            end
            if (state_q == PV_WAIT) begin
                handler_q <= vt_rd_data_i;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        vt_rd_en_o     = 1'b0;
        vt_rd_addr_o   = '0;
        take_o         = 1'b0;
        take_level_o   = '0;
        take_vaddr_o   = '0;
        take_handler_o = '0;
        push           = 1'b0;
        clr_vec        = '0;
        st_idle        = 1'b0;
        unique case (state_q)
            PV_IDLE: st_idle = 1'b1;
            PV_READ: begin
                vt_rd_en_o   = 1'b1;
                vt_rd_addr_o = vaddr;
            end
            PV_WAIT: ;
            PV_TAKE: begin
                take_o         = 1'b1;
                take_level_o   = sel_q;
                take_vaddr_o   = vaddr;
                take_handler_o = handler_q;
                push           = 1'b1;
                clr_vec        = NUM_LVL'(1) << sel_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
    parameter int LVL_W  = 3,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_done_i,
    input logic              int_en_i,
    input logic              nest_en_i,
    input logic              ret_i,
    input logic              vt_rd_en_o,
    input logic [ADDR_W-1:0] vt_rd_addr_o,
    input logic              take_o,
    input logic [LVL_W-1:0]  take_level_o,
    input logic [ADDR_W-1:0] take_vaddr_o,
    input logic              st_idle,
    input logic              stk_empty,
    input logic              stk_full,
    input logic [LVL_W-1:0]  stk_top,
    input logic              push
);

    AST_READ_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        vt_rd_en_o |-> ($past(insn_done_i) && $past(st_idle) && $past(int_en_i))); // R3

    AST_TAKE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        vt_rd_en_o |-> ##2 take_o); // R4

    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o); // R4

    AST_TAKE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (take_vaddr_o == $past(vt_rd_addr_o, 2))); // R4

    AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !stk_empty) |-> (take_level_o > stk_top)); // R5

    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && !int_en_i) |=> !vt_rd_en_o); // R9

    AST_NEST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && !nest_en_i && !stk_empty) |=> !vt_rd_en_o); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && stk_full && !ret_i)); // R6

endmodule

bind pvic_top pvic_checker #(
    .LVL_W  (LVL_W),
    .ADDR_W (ADDR_W)
) i_pvic_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_done_i  (insn_done_i),
    .int_en_i     (int_en_i),
    .nest_en_i    (nest_en_i),
    .ret_i        (ret_i),
    .vt_rd_en_o   (vt_rd_en_o),
    .vt_rd_addr_o (vt_rd_addr_o),
    .take_o       (take_o),
    .take_level_o (take_level_o),
    .take_vaddr_o (take_vaddr_o),
    .st_idle      (st_idle),
    .stk_empty    (stk_empty),
    .stk_full     (stk_full),
    .stk_top      (stk_top),
    .push         (push)
);

// File: tb/test_pvic_top.sv
module test_pvic_top;

    localparam logic [15:0] BASE = 16'h0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq = '0;
    logic        insn_done = 1'b0;
    logic        int_en = 1'b1;
    logic        nest_en = 1'b1;
    logic        ret = 1'b0;
    logic        vt_rd_en;
    logic [15:0] vt_rd_addr;
    logic [15:0] vt_rd_data = '0;
    logic        take;
    logic [2:0]  take_level;
    logic [15:0] take_vaddr;
    logic [15:0] take_handler;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [7:0] pend_m = '0;
    int         stk_m [8];
    int         dep_m = 0;

    always #5 clk = ~clk;

    pvic_top #(
        .NUM_LVL   (8),
        .STK_DEPTH (8),
        .ADDR_W    (16),
        .VT_BASE   (BASE)
    ) i_pvic_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .irq_i          (irq),
        .insn_done_i    (insn_done),
        .int_en_i       (int_en),
        .nest_en_i      (nest_en),
        .ret_i          (ret),
        .vt_rd_en_o     (vt_rd_en),
        .vt_rd_addr_o   (vt_rd_addr),
        .vt_rd_data_i   (vt_rd_data),
        .take_o         (take),
        .take_level_o   (take_level),
        .take_vaddr_o   (take_vaddr),
        .take_handler_o (take_handler)
    );

    function automatic logic [15:0] vt_word(input logic [15:0] a);
        return (a * 16'd7) ^ 16'h5A00;
    endfunction

    // Vector table: one-cycle read latency
    always_ff @(posedge clk) begin
        if (vt_rd_en) vt_rd_data <= vt_word(vt_rd_addr);
    end

    function automatic int exp_win();
        if (!int_en) return -1;
        for (int i = 7; i >= 0; i--) begin
            if (pend_m[i] && (dep_m == 0 || (nest_en && i > stk_m[dep_m-1]))) return i;
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk) irq = m;
        @(negedge clk) irq = '0;
        pend_m |= m;
    endtask

    task automatic do_ret();
        @(negedge clk) ret = 1'b1;
        @(negedge clk) ret = 1'b0;
        if (dep_m > 0) dep_m--;
    endtask

    task automatic boundary(input string tag, input bit hit_same, input bit hit_ret);
        int          w;
        logic [15:0] ea;
        w  = exp_win();
        ea = BASE + 16'(4 * (w < 0 ? 0 : w));
        @(negedge clk) insn_done = 1'b1;
        @(negedge clk);
        if (w < 0) begin
            chk(vt_rd_en == 1'b0, tag, "read without winner", int'(vt_rd_en), 0);
        end else begin
            chk(vt_rd_en == 1'b1, tag, "read strobe", int'(vt_rd_en), 1);
            chk(vt_rd_addr == ea, tag, "read addr", int'(vt_rd_addr), int'(ea));
        end
        insn_done = 1'b0;
        @(negedge clk);
        chk(take == 1'b0, tag, "early take", int'(take), 0);
        @(negedge clk);
        if (w < 0) begin
            chk(take == 1'b0, tag, "unexpected take", int'(take), 0);
        end else begin
            chk(take == 1'b1, tag, "take pulse", int'(take), 1);
            chk(take_level == 3'(w), tag, "take level", int'(take_level), w);
            chk(take_vaddr == ea, tag, "take vaddr", int'(take_vaddr), int'(ea));
            chk(take_handler == vt_word(ea), tag, "handler", int'(take_handler),
                int'(vt_word(ea)));
            if (hit_same) irq[w] = 1'b1;
            if (hit_ret) ret = 1'b1;
        end
        @(negedge clk);
        chk(take == 1'b0, tag, "take longer than one cycle", int'(take), 0);
        irq = '0;
        ret = 1'b0;
        if (w >= 0) begin
            if (hit_ret && dep_m > 0) dep_m--;
            stk_m[dep_m] = w;
            dep_m++;
            if (!hit_same) pend_m[w] = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(take == 1'b0, "R1", "take after reset", int'(take), 0);
        chk(vt_rd_en == 1'b0, "R1", "read after reset", int'(vt_rd_en), 0);
        boundary("R1", 0, 0);

        // R3/R4 single request; R5 masking and preemption; R6/R8 unwinding
        pulse(8'h04);
        boundary("R4", 0, 0);
        pulse(8'h06);
        boundary("R5", 0, 0);
        pulse(8'h20);
        boundary("R5", 0, 0);
        do_ret();
        boundary("R6", 0, 0);
        do_ret();
        boundary("R8", 0, 0);
        do_ret();
        boundary("R8", 0, 0);
        do_ret();

        // R7 merged requests
        pulse(8'h10);
        pulse(8'h10);
        boundary("R7", 0, 0);
        do_ret();
        boundary("R7", 0, 0);

        // R3 priority order
        pulse(8'h92);
        boundary("R3", 0, 0);
        do_ret();
        boundary("R3", 0, 0);
        do_ret();
        boundary("R3", 0, 0);
        do_ret();

        // R9 global enable
        @(negedge clk) int_en = 1'b0;
        pulse(8'h40);
        boundary("R9", 0, 0);
        @(negedge clk) int_en = 1'b1;
        boundary("R9", 0, 0);
        do_ret();

        // R10 nesting disabled
        @(negedge clk) nest_en = 1'b0;
        pulse(8'h08);
        boundary("R10", 0, 0);
        pulse(8'h80);
        boundary("R10", 0, 0);
        do_ret();
        boundary("R10", 0, 0);
        do_ret();
        @(negedge clk) nest_en = 1'b1;

        // R11 new edge during the take cycle
        pulse(8'h20);
        boundary("R11", 1, 0);
        do_ret();
        boundary("R11", 0, 0);
        do_ret();

        // R12 return in the take cycle
        pulse(8'h04);
        boundary("R12", 0, 0);
        pulse(8'h40);
        boundary("R12", 0, 1);
        do_ret();
        pulse(8'h01);
        boundary("R12", 0, 0);
        do_ret();

        // R13 return with nothing in service
        do_ret();
        do_ret();
        pulse(8'h01);
        boundary("R13", 0, 0);
        do_ret();

        // R2 held line
        @(negedge clk) irq = 8'h08;
        pend_m[3] = 1'b1;
        @(negedge clk);
        boundary("R2", 0, 0);
        irq = 8'h08;
        @(negedge clk) ret = 1'b1;
        @(negedge clk) ret = 1'b0;
        if (dep_m > 0) dep_m--;
        @(negedge clk) insn_done = 1'b1;
        @(negedge clk) insn_done = 1'b0;
        chk(vt_rd_en == 1'b0, "R2", "held line re-requested", int'(vt_rd_en), 0);
        @(negedge clk) irq = '0;
        @(negedge clk);

        // Random mix checked against the model (R3 and others)
        for (int it = 0; it < 400; it++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 4) begin
                if ($urandom % 4 == 0) pulse(8'($urandom));
                else pulse(8'(1) << ($urandom % 8));
            end else if (r < 7) begin
                boundary("R3", ($urandom % 8) == 0, ($urandom % 8) == 0);
            end else if (r < 9) begin
                do_ret();
            end else begin
                @(negedge clk);
                int_en  = ($urandom % 4) != 0;
                nest_en = ($urandom % 4) != 0;
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule